// File: doc/BRIEF.md
# Serial Joystick Key Mapper

The block gathers sixteen joystick switch inputs from a chain of two external 8-bit parallel-in/serial-out shift registers. It uses one load wire, one shift-clock wire and one data wire. Scans repeat without a break. Each scan starts with a parallel-load pulse and then clocks the sixteen bits in one at a time. The word is committed as a whole once the last bit has arrived.

The committed word is visible to the CPU through an 8-bit joystick read port. Bit 7 of a write to that port selects which half of the word later reads return.

The same word also drives a programmable keyboard overlay. Each input owns a row of 40 bits in a map. The row names the keys that the input presses. The 40-bit key output is the OR of the rows of all active inputs. It is meant to be ORed into the keyboard matrix, so one input may press several keys, and several inputs may press the same key.

Top module: `joy_keymap`

## Requirements
- R1: While reset is held, `keys_out` is zero, `port_rdata` is zero and `sr_load` is high.
- R2: Each scan lasts 32*DIV clock cycles. `sr_load` is high for the first DIV cycles. After that, `sr_clk` is low for DIV cycles and high for DIV cycles, alternately, which gives 15 high phases. `sr_load` and `sr_clk` are never high together.
- R3: The bit present on `sr_data` before any shift clock becomes word bit 0. The bit present after k rising edges of `sr_clk` becomes word bit k. Bits 7..0 therefore come from the chip wired directly to `sr_data`. A one on the wire means the input is active.
- R4: The captured word changes only at the clock edge that ends a scan, 32*DIV cycles after that scan's load began. It takes the value that was loaded during that scan, all sixteen bits at once.
- R5: After reset, `port_rdata` returns word bits 7..0.
- R6: A write with `port_wdata[7]`=1 makes later reads return word bits 15..8. A write with bit 7=0 returns reads to bits 7..0. Bits 6..0 of the write have no effect.
- R7: `map_idx_we` loads the row index from `map_wdata[3:0]` and leaves the map unchanged. `map_row_we` writes `map_wdata` (bit n = key n) into the indexed row.
- R8: `keys_out` bit n is high exactly when some active input has bit n set in its row. One row may set several keys.
- R9: After reset every row is zero, so no key is pressed even when all inputs are active.
- R10: A row write is reflected on `keys_out` in the cycle after the write edge, with no wait for a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_load | output | 1 | Parallel-load pulse to the shift-register chain |
| sr_clk | output | 1 | Shift clock to the chain |
| sr_data | input | 1 | Serial data from the chain |
| port_wr | input | 1 | Write strobe for the joystick port |
| port_wdata | input | 8 | Joystick port write data; bit 7 selects the bank |
| port_rdata | output | 8 | Joystick port read data |
| map_idx_we | input | 1 | Load the row index |
| map_row_we | input | 1 | Write the indexed map row |
| map_wdata | input | 40 | Index or row data |
| keys_out | output | 40 | Keys pressed by the joystick |

## Verification
The load and shift-clock outputs are due in the same cycle as the scan phase that produces them. The captured word reaches `port_rdata` and `keys_out` one edge after the last sample of a scan, which is 32*DIV edges after that scan's load began. A bank write or a map row write shows on the outputs one edge after its strobe. The bench keeps its own edge count since reset, together with a behavioural map and bank. It applies every stimulus just after a rising edge and compares all outputs at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/joy_keymap.sv
module joy_keymap #(
  parameter int N_IN   = 16,
  parameter int N_KEYS = 40,
  parameter int DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sr_load,
  output logic              sr_clk,
  input  logic              sr_data,
  input  logic              port_wr,
  input  logic [7:0]        port_wdata,
  output logic [7:0]        port_rdata,
  input  logic              map_idx_we,
  input  logic              map_row_we,
  input  logic [N_KEYS-1:0] map_wdata,
  output logic [N_KEYS-1:0] keys_out
);
  localparam int PW    = N_IN / 2;
  localparam int STEPS = 2 * N_IN;
  localparam int STW   = $clog2(STEPS);
  localparam int IDXW  = $clog2(N_IN);
  localparam int DW    = $clog2(DIV + 1);

  logic [DW-1:0]     cnt;
  logic [STW-1:0]    step;
  logic [N_IN-1:0]   shreg, word, cap;
  logic              bank;
  logic [IDXW-1:0]   idx;
  logic [N_KEYS-1:0] map_q [N_IN];

  wire tick   = (cnt == DW'(DIV - 1));
  wire last   = (step == STW'(STEPS - 1));
  wire commit = tick & last;
  wire [IDXW-1:0] bit_sel = step[STW-1:1];
  wire unused_wbits = ^port_wdata[PW-2:0];

  assign sr_load    = (step == '0);
  assign sr_clk     = (step != '0) & ~step[0];
  assign port_rdata = bank ? word[N_IN-1:PW] : word[PW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      step <= '0;
    end else if (tick) begin
      cnt  <= '0;
      step <= last ? '0 : step + 1'b1;
    end else
      cnt <= cnt + 1'b1;

  always_comb begin
    cap = shreg;
    cap[bit_sel] = sr_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      word  <= '0;
    end else if (tick && step[0]) begin
      shreg <= cap;
      if (last) word <= cap;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bank <= 1'b0;
    else if (port_wr) bank <= port_wdata[PW-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx <= '0;
      for (int i = 0; i < N_IN; i++) map_q[i] <= '0;
    end else begin
      if (map_idx_we) idx <= map_wdata[IDXW-1:0];
      if (map_row_we) map_q[idx] <= map_wdata;
    end

  always_comb begin
    keys_out = '0;
    for (int i = 0; i < N_IN; i++)
      if (word[i]) keys_out = keys_out | map_q[i];
  end
endmodule

module joy_keymap_chk #(
  parameter int N_IN   = 16,
  parameter int N_KEYS = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_load,
  input logic              sr_clk,
  input logic              port_wr,
  input logic [7:0]        port_wdata,
  input logic              bank,
  input logic [N_IN-1:0]   word,
  input logic              commit,
  input logic [N_KEYS-1:0] keys_out
);
  // R2
  load_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_load && sr_clk));
  // R2
  load_end_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_load) |-> !sr_clk);
  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(word));
  // R6
  bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> bank == $past(port_wdata[7]));
  // R8
  idle_keys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word == '0) |-> (keys_out == '0));
endmodule

bind joy_keymap joy_keymap_chk #(.N_IN(N_IN), .N_KEYS(N_KEYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sr_load(sr_load), .sr_clk(sr_clk),
  .port_wr(port_wr), .port_wdata(port_wdata), .bank(bank), .word(word),
  .commit(commit), .keys_out(keys_out));

// File: tb/joy_keymap_test.sv
module joy_keymap_test;
  localparam int N_IN = 16, N_KEYS = 40, DIV = 2;
  localparam int SCAN = 2 * N_IN * DIV;

  logic clk = 0, rst_n = 0;
  logic sr_load, sr_clk, sr_data;
  logic port_wr = 0;
  logic [7:0] port_wdata = 0, port_rdata;
  logic map_idx_we = 0, map_row_we = 0;
  logic [N_KEYS-1:0] map_wdata = 0, keys_out;

  always #5 clk = ~clk;

  joy_keymap uut (.*);

  int total = 0, fails = 0;
  bit running = 0, done = 0;

  logic [15:0] pattern = 0, chain = 0;
  logic prev_clk = 0;
  assign sr_data = chain[0];

  always @(negedge clk) begin
    if (sr_load) chain <= pattern;
    else if (sr_clk && !prev_clk) chain <= chain >> 1;
    prev_clk <= sr_clk;
  end

  int m_cnt;
  logic [15:0] m_word, pat_l;
  logic m_bank;
  logic [3:0] m_idx;
  logic [N_KEYS-1:0] m_map [16];

  always @(negedge clk) if (m_cnt < DIV) pat_l <= pattern;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_word <= 0; m_bank <= 0; m_idx <= 0;
      for (int i = 0; i < 16; i++) m_map[i] <= '0;
    end else begin
      if (m_cnt == SCAN - 1) begin m_cnt <= 0; m_word <= pat_l; end
      else m_cnt <= m_cnt + 1;
      if (port_wr) m_bank <= port_wdata[7];
      if (map_idx_we) m_idx <= map_wdata[3:0];
      if (map_row_we) m_map[m_idx] <= map_wdata;
    end
  end

  function automatic logic [N_KEYS-1:0] keys_of(logic [15:0] w);
    logic [N_KEYS-1:0] k = '0;
    for (int i = 0; i < 16; i++) if (w[i]) k |= m_map[i];
    return k;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    int st;
    st = m_cnt / DIV;
    chk("R2 sr_load", sr_load, st == 0);
    chk("R2 sr_clk", sr_clk, st != 0 && st % 2 == 0);
    chk("R3 port_rdata", port_rdata, m_bank ? m_word[15:8] : m_word[7:0]);
    chk("R8 keys_out", keys_out, keys_of(m_word));
  end

  task automatic step_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_row(input int r, input logic [N_KEYS-1:0] v);
    @(posedge clk); #1 map_idx_we = 1; map_wdata = N_KEYS'(r) | {8'hA0, 32'h0};
    @(posedge clk); #1 map_idx_we = 0; map_row_we = 1; map_wdata = v;
    @(posedge clk); #1 map_row_we = 0; map_wdata = '0;
  endtask

  task automatic port_write(input logic [7:0] d);
    @(posedge clk); #1 port_wr = 1; port_wdata = d;
    @(posedge clk); #1 port_wr = 0; port_wdata = 0;
  endtask

  initial begin
    step_n(3);
    @(negedge clk);
    chk("R1 keys", keys_out, 0);
    chk("R1 rdata", port_rdata, 0);
    chk("R1 load", sr_load, 1);
    @(posedge clk); #1 rst_n = 1; running = 1;

    pattern = 16'hFFFF;
    step_n(2 * SCAN);
    @(negedge clk);
    chk("R9 no keys mapped", keys_out, 0);
    chk("R5 low byte", port_rdata, 8'hFF);

    set_row(0, 40'h21);
    @(negedge clk);
    chk("R10 immediate row", keys_out, 40'h21);
    set_row(9, 40'h80_0000_0000);
    set_row(15, 40'h0E);
    set_row(8, 40'h20);
    @(negedge clk);
    chk("R7 rows", keys_out, 40'h80_0000_002F);

    pattern = 16'h0001;
    step_n(2 * SCAN);
    @(negedge clk);
    chk("R8 one input two keys", keys_out, 40'h21);
    chk("R3 bit0", port_rdata, 8'h01);

    port_write(8'h80);
    @(negedge clk);
    chk("R6 upper bank", port_rdata, 8'h00);
    pattern = 16'h8100;
    step_n(2 * SCAN);
    @(negedge clk);
    chk("R3 upper bits", port_rdata, 8'h81);
    chk("R8 shared key", keys_out, 40'h2E);
    port_write(8'h7F);
    @(negedge clk);
    chk("R6 low bits ignored", port_rdata, 8'h00);

    @(negedge clk);
    while (!sr_load) @(negedge clk);
    while (sr_load) @(negedge clk);
    @(posedge clk); #1 pattern = 16'h00FF;
    @(negedge clk);
    while (!sr_load) @(negedge clk);
    chk("R4 old scan kept", port_rdata, 8'h00);
    while (sr_load) @(negedge clk);
    while (!sr_load) @(negedge clk);
    chk("R4 new scan", port_rdata, 8'hFF);

    port_write(8'hFF);
    @(posedge clk); #1 rst_n = 0; running = 0;
    step_n(2);
    @(posedge clk); #1 rst_n = 1; running = 1;
    step_n(2 * SCAN);
    @(negedge clk);
    chk("R5 low after reset", port_rdata, 8'hFF);
    chk("R9 map cleared", keys_out, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule